// File: doc/BRIEF.md
# Thermal Limit Alert and Shutdown Logic

This block watches three signed 8-bit temperature channels and compares each stored reading against a high limit for that channel. A reading at or above its limit is a limit event. Every event sets a sticky status bit, and the status bits drive an active-low alert pin. A configuration register can also route a channel's event to an active-low system shutdown pin. The shutdown pin follows the live comparison, so it releases on its own once the temperature falls back below the limit.

Readings arrive on one valid/ready stream per channel. Ready is held high whenever the block is out of reset, so the block never applies back-pressure. A reading is taken on every cycle where valid and ready are both high. A byte-wide register write port loads the configuration, the limits and a per-channel alert mask. A software-lock input freezes the configuration register only.

On the third channel, an anti-parallel diode mode can be enabled. Turning that mode on suppresses every third-channel comparison until the next third-channel reading has been accepted. Turning the mode off cancels any suppression that is still pending.

Top module: `thermal_guard`

## Requirements
- R1: After reset, the configuration register and the alert-mask register are 0x00, all limits are 0x7F, stored temperatures are 0x80, `status` is 0, and `alert_n` and `shdn_n` are both 1.
- R2: A channel's limit event is true when its stored temperature is greater than or equal to its limit, both compared as two's-complement signed values.
- R3: A status bit sets on the clock edge after its channel's event becomes true. It stays set until a `stat_rd` pulse. On that pulse each bit reloads from the current event, so a bit whose condition is still present stays set.
- R4: Configuration bit 7 masks alert globally. While it is 1, `alert_n` stays high. While it is 0, `alert_n` goes low one cycle after any status bit is set whose per-channel mask bit is clear.
- R5: The alert-mask register is at address 0x28. Bits 0, 1 and 2 mask channels 0, 1 and 2 from the alert, and they do not affect `status`.
- R6: Configuration bits 1, 2 and 3 link channels 0, 1 and 2 to shutdown. `shdn_n` is registered and goes low on the edge after any linked channel's event is true. It returns high on the edge after no linked event remains.
- R7: A channel whose link bit is 0 never pulls `shdn_n` low, whatever its temperature. Its event still reaches `status` and the alert path.
- R8: When a write changes configuration bit 0 from 0 to 1, the channel-2 event is forced false until a channel-2 reading is accepted. Comparison resumes with that reading. Writing bit 0 back to 0 ends the suppression at once.
- R9: While `sw_lock` is 1, writes to the configuration register at address 0x20 have no effect. Writes to the limits and to the alert mask are still taken.
- R10: `t_ready` is all ones out of reset. A reading on channel i is stored on every edge where `t_valid[i]` is high.
- R11: Channel i's limit is written at address 0x30+i. A write takes effect in the event comparison from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_valid | input | 3 | Per-channel reading valid |
| t_ready | output | 3 | Per-channel reading ready, high out of reset |
| t_data | input | 24 | Signed readings, channel i in bits 8i+7:8i |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| sw_lock | input | 1 | Freezes the configuration register |
| stat_rd | input | 1 | Status read pulse, clears the status bits |
| status | output | 3 | Sticky per-channel limit-event bits |
| alert_n | output | 1 | Active-low alert |
| shdn_n | output | 1 | Active-low system shutdown |

## Verification
The assertions assume that `wr_en`, `stat_rd` and `t_valid` are single-cycle pulses driven cleanly between clock edges. They also assume the suppression window opens only through a register write that raises configuration bit 0. The stimulus drives every input on the falling edge and holds each pulse for exactly one cycle. After each stimulus it waits two full cycles, so the registered shutdown and alert outputs settle before the scoreboard compares them. Temperatures in the stimulus sit on both sides of each limit, and they include negative readings and an exact tie with the limit.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  localparam logic [7:0] CFG_ADDR   = 8'h20;
  localparam logic [7:0] IMASK_ADDR = 8'h28;
  localparam logic [7:0] LIM_BASE   = 8'h30;
  localparam int         CFG_MASK_BIT = 7;
  localparam int         CFG_APD_BIT  = 0;
  localparam int         CFG_LINK_LSB = 1;
  localparam logic [7:0] LIMIT_RST  = 8'h7F;
  localparam logic [7:0] TEMP_RST   = 8'h80;
endpackage

// File: rtl/tl_cfg_regs.sv
module tl_cfg_regs
  import thermal_pkg::*;
#(
  parameter int NCH = 3,
  parameter int TW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              sw_lock,
  input  logic              last_take,
  output logic              gmask,
  output logic [NCH-1:0]    link,
  output logic [NCH-1:0]    imask,
  output logic              apd_pend,
  output logic [NCH*TW-1:0] limits
);
  localparam int LW = NCH;

  logic [7:0]    cfg_q;
  logic [LW-1:0] imask_q;
  logic          pend_q;
  logic          cfg_we;
  logic          apd_rise;
  logic          apd_fall;

  assign cfg_we   = wr_en && !sw_lock && (wr_addr == CFG_ADDR);
  assign apd_rise = cfg_we && wr_data[CFG_APD_BIT] && !cfg_q[CFG_APD_BIT];
  assign apd_fall = cfg_we && !wr_data[CFG_APD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= 8'h00;
      imask_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= wr_data;
      if (wr_en && wr_addr == IMASK_ADDR) imask_q <= wr_data[LW-1:0];
      if (apd_rise)                       pend_q <= 1'b1;
      else if (apd_fall || last_take)     pend_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_lim
    logic [TW-1:0] lim_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lim_q <= TW'(LIMIT_RST);
      else if (wr_en && wr_addr == LIM_BASE + 8'(i)) lim_q <= wr_data[TW-1:0];
    end
    assign limits[i*TW +: TW] = lim_q;
  end

  assign gmask    = cfg_q[CFG_MASK_BIT];
  assign link     = cfg_q[CFG_LINK_LSB +: NCH];
  assign imask    = imask_q;
  assign apd_pend = pend_q;

  p_lock_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sw_lock && wr_addr == CFG_ADDR) |=> $stable(cfg_q));
  p_apd_arms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_q[CFG_APD_BIT]) |-> pend_q);
  p_apd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[CFG_APD_BIT] |-> !pend_q);
endmodule

// File: rtl/tl_channel.sv
module tl_channel
  import thermal_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [TW-1:0] data,
  input  logic [TW-1:0] limit,
  input  logic          suppress,
  output logic          hit
);
  logic [TW-1:0] temp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    temp_q <= TW'(TEMP_RST);
    else if (take) temp_q <= data;
  end

  assign hit = !suppress && ($signed(temp_q) >= $signed(limit));

  p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (temp_q == $past(data)));
endmodule

// File: rtl/tl_status.sv
module tl_status #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic [NCH-1:0] link,
  input  logic [NCH-1:0] imask,
  input  logic           gmask,
  input  logic           rd_clr,
  output logic [NCH-1:0] status,
  output logic           alert_n,
  output logic           shdn_n
);
  logic [NCH-1:0] st_q;
  logic           al_q;
  logic           sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      al_q <= 1'b1;
      sd_q <= 1'b1;
    end else begin
      st_q <= rd_clr ? hit : (st_q | hit);
      al_q <= !(!gmask && |(st_q & ~imask));
      sd_q <= !(|(hit & link));
    end
  end

  assign status  = st_q;
  assign alert_n = al_q;
  assign shdn_n  = sd_q;

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((st_q & $past(st_q)) == $past(st_q)));
  p_mask_alert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |=> alert_n);
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(hit & link)) |=> shdn_n);
  p_unlinked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (link == '0) |=> shdn_n);
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_pkg::*;
#(
  parameter int NCH = 3,
  parameter int TW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    t_valid,
  output logic [NCH-1:0]    t_ready,
  input  logic [NCH*TW-1:0] t_data,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              sw_lock,
  input  logic              stat_rd,
  output logic [NCH-1:0]    status,
  output logic              alert_n,
  output logic              shdn_n
);
  localparam int LAST = NCH - 1;

  logic              gmask;
  logic [NCH-1:0]    link;
  logic [NCH-1:0]    imask;
  logic              apd_pend;
  logic [NCH*TW-1:0] limits;
  logic [NCH-1:0]    take;
  logic [NCH-1:0]    hit;

  assign t_ready = {NCH{rst_n}};
  assign take    = t_valid & t_ready;

  tl_cfg_regs #(.NCH(NCH), .TW(TW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sw_lock(sw_lock), .last_take(take[LAST]),
    .gmask(gmask), .link(link), .imask(imask), .apd_pend(apd_pend),
    .limits(limits)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic supp;
    if (i == LAST) begin : g_apd
      assign supp = apd_pend;
    end else begin : g_plain
      assign supp = 1'b0;
    end
    tl_channel #(.TW(TW)) u_ch (
      .clk(clk), .rst_n(rst_n), .take(take[i]),
      .data(t_data[i*TW +: TW]), .limit(limits[i*TW +: TW]),
      .suppress(supp), .hit(hit[i])
    );
  end

  tl_status #(.NCH(NCH)) u_st (
    .clk(clk), .rst_n(rst_n), .hit(hit), .link(link), .imask(imask),
    .gmask(gmask), .rd_clr(stat_rd), .status(status),
    .alert_n(alert_n), .shdn_n(shdn_n)
  );

  p_supp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    apd_pend |-> !hit[LAST]);
endmodule

// File: tb/thermal_guard_bench.sv
module thermal_guard_bench;
  localparam int NCH = 3;
  localparam int TW  = 8;

  typedef struct {
    logic [2:0] st;
    logic       al;
    logic       sd;
    string      tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    t_valid = '0;
  logic [NCH-1:0]    t_ready;
  logic [NCH*TW-1:0] t_data = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              sw_lock = 1'b0;
  logic              stat_rd = 1'b0;
  logic [NCH-1:0]    status;
  logic              alert_n;
  logic              shdn_n;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];
  exp_t cur;

  always #4 clk = ~clk;

  thermal_guard #(.NCH(NCH), .TW(TW)) u_thermal_guard (
    .clk(clk), .rst_n(rst_n), .t_valid(t_valid), .t_ready(t_ready),
    .t_data(t_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sw_lock(sw_lock), .stat_rd(stat_rd), .status(status),
    .alert_n(alert_n), .shdn_n(shdn_n)
  );

  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      n_chk++;
      if (status !== cur.st || alert_n !== cur.al || shdn_n !== cur.sd) begin
        n_fail++;
        $display("FAIL %s: got st=%b al=%b sd=%b, expected st=%b al=%b sd=%b",
                 cur.tag, status, alert_n, shdn_n, cur.st, cur.al, cur.sd);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic [2:0] st, input logic al,
                            input logic sd, input string tag);
    exp_t e;
    step(2);
    e.st = st; e.al = al; e.sd = sd; e.tag = tag;
    exp_q.push_back(e);
    step(1);
  endtask

  task automatic put_temp(input int ch, input logic [7:0] v);
    t_data[ch*TW +: TW] = v;
    t_valid[ch] = 1'b1;
    step(1);
    t_valid[ch] = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd_clear();
    stat_rd = 1'b1;
    step(1);
    stat_rd = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    n_chk++;
    if (t_ready !== 3'b111) begin
      n_fail++;
      $display("FAIL R10: t_ready=%b expected 111", t_ready);
    end
    expect_out(3'b000, 1'b1, 1'b1, "R1 reset state");

    wr(8'h30, 8'd50);
    put_temp(0, 8'd49);
    expect_out(3'b000, 1'b1, 1'b1, "R2 below limit");
    put_temp(0, 8'd50);
    expect_out(3'b001, 1'b0, 1'b1, "R2/R7 tie with limit, unlinked");
    put_temp(0, 8'd20);
    expect_out(3'b001, 1'b0, 1'b1, "R3 sticky after cooling");
    rd_clear();
    expect_out(3'b000, 1'b1, 1'b1, "R3 read clears");

    wr(8'h20, 8'h02);
    put_temp(0, 8'd60);
    expect_out(3'b001, 1'b0, 1'b0, "R6 linked shutdown");
    rd_clear();
    expect_out(3'b001, 1'b0, 1'b0, "R3 clear while present");
    put_temp(0, 8'd10);
    expect_out(3'b001, 1'b0, 1'b1, "R6 shutdown released");
    rd_clear();
    wr(8'h20, 8'h00);

    wr(8'h31, 8'hF6);
    put_temp(1, 8'hF0);
    expect_out(3'b000, 1'b1, 1'b1, "R2 negative below");
    put_temp(1, 8'hFB);
    expect_out(3'b010, 1'b0, 1'b1, "R2/R11 negative above");
    put_temp(1, 8'h80);
    rd_clear();

    wr(8'h20, 8'h80);
    put_temp(0, 8'd60);
    expect_out(3'b001, 1'b1, 1'b1, "R4 global mask");
    wr(8'h20, 8'h00);
    expect_out(3'b001, 1'b0, 1'b1, "R4 unmask alerts");
    put_temp(0, 8'd10);
    rd_clear();

    wr(8'h28, 8'h01);
    put_temp(0, 8'd60);
    expect_out(3'b001, 1'b1, 1'b1, "R5 channel mask");
    wr(8'h28, 8'h00);
    expect_out(3'b001, 1'b0, 1'b1, "R5 channel unmask");
    put_temp(0, 8'd10);
    rd_clear();

    sw_lock = 1'b1;
    wr(8'h20, 8'h02);
    put_temp(0, 8'd60);
    expect_out(3'b001, 1'b0, 1'b1, "R9 locked write ignored");
    sw_lock = 1'b0;
    wr(8'h20, 8'h02);
    expect_out(3'b001, 1'b0, 1'b0, "R9 unlocked write taken");
    put_temp(0, 8'd10);
    rd_clear();
    wr(8'h20, 8'h00);

    wr(8'h32, 8'd30);
    wr(8'h20, 8'h08);
    put_temp(2, 8'd40);
    expect_out(3'b100, 1'b0, 1'b0, "R6 channel 2 linked");
    wr(8'h20, 8'h09);
    rd_clear();
    expect_out(3'b000, 1'b1, 1'b1, "R8 suppressed after enable");
    put_temp(2, 8'd40);
    expect_out(3'b100, 1'b0, 1'b0, "R8 resumes after update");
    wr(8'h20, 8'h08);
    wr(8'h20, 8'h09);
    expect_out(3'b100, 1'b0, 1'b1, "R8 suppressed again");
    wr(8'h20, 8'h08);
    expect_out(3'b100, 1'b0, 1'b0, "R8 cancel on disable");

    step(2);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule